// File: doc/BRIEF.md
# Serial Display Frame Loader

This block takes display frames that a host shifts in one bit at a time and writes the segment part of each frame into one or more of four display latches. Each latch belongs to one common line of a multiplexed LCD. A frame carries the segment bits, then three filler bits, then four select flags, and the select flags always come last. The host drives a data line, a shift clock and a load strobe. All three reach the block without a clock of their own, so the block samples them with its own system clock. It finds the rising edges of the shift clock and of the load strobe and acts on those edges.

On a rising edge of the load strobe, the segment bits now in the shift register are copied into every latch whose select flag is set. A scan block elsewhere reads the four latch outputs and drives the panel. Because the select flags sit at the tail of the register, the host may send a shorter frame when the panel uses fewer segments. The upper latch positions then take whatever bits are left over in the register.

Top module: `seg_frame_loader`

## Requirements
- R1: While reset is held, all four latches and the shift register clear to zero, so every segment is off once reset is released.
- R2: On each rising edge of the shift clock, the value on the data line enters bit 0 of a 56-bit register and every older bit moves up one position. A full frame is sent segment bit D49 first, down to D1, then three filler bits, then select flags C1, C2, C3 and C4, with C4 last.
- R3: Select flag C1 (register bit 3) targets latch 0. C2 (bit 2) targets latch 1, C3 (bit 1) targets latch 2 and C4 (bit 0) targets latch 3.
- R4: When several select flags are 1, one load writes the same segment data into every selected latch. For example, all four flags with all-zero data clears the whole panel.
- R5: A latch whose select flag is 0 keeps its contents through a load. A load with all flags 0 changes no latch, and latches never change without a load.
- R6: A write happens once, on the rising edge of the load strobe. Holding the strobe high while more bits are shifted in writes nothing further until the strobe falls and rises again.
- R7: A frame with fewer than 49 segment bits is accepted. Its select flags come from the last four bits shifted in. Latch positions that the short frame does not cover take the stale register bits held at those positions.
- R8: The values of the three filler bits (register bits 4 to 6) have no effect on which latches are written or on the data written.
- R9: Latch output bit n-1 carries segment bit Dn, which is taken from register bit n+6. A 1 means the segment is on and a 0 means it is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data_i | input | 1 | Serial frame data from the host, not synchronised to clk |
| ser_clk_i | input | 1 | Host shift clock; data is taken on its rising edge |
| load_i | input | 1 | Load strobe; its rising edge writes the selected latches |
| com_latch_o | output | 4x49 | Display latches; index k belongs to common k+1, bit n-1 is segment n |

## Verification
The hardest case to reach from the ports is a load whose select flags come from a truncated frame. In that case the upper latch positions must take the leftovers of the frame sent before it. The stimulus therefore sends full frames with distinct patterns first. It then shifts a 30-segment frame behind them, so the stale upper bits are known and differ from the new ones. A second hard case is a strobe held high while a whole new frame is shifted in. The bench holds the strobe high, shifts the new frame, checks that nothing was rewritten, and only then releases the strobe and raises it again.

// File: rtl/frame_loader_pkg.sv
// Package: shared geometry of the serial display frame.
// Assumes: the select field occupies the lowest register bits, the filler
// field sits above it and the segment field sits on top.
package frame_loader_pkg;

    localparam int unsigned SEG_BITS_DEF   = 49;
    localparam int unsigned FILL_BITS_DEF  = 3;
    localparam int unsigned NUM_COM_DEF    = 4;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Total frame length for a given geometry.
    function automatic int unsigned frame_len(input int unsigned seg_bits,
                                              input int unsigned fill_bits,
                                              input int unsigned num_com);
        return seg_bits + fill_bits + num_com;
    endfunction

    // Lowest register bit that holds segment bit D1.
    function automatic int unsigned seg_base(input int unsigned fill_bits,
                                             input int unsigned num_com);
        return fill_bits + num_com;
    endfunction

endpackage

// File: rtl/fl_bit_sync.sv
// Module: fl_bit_sync
// Brings one asynchronous level into the clk domain through a chain of
// flip-flops. Assumes: the input stays stable for longer than STAGES clocks
// around each change.
module fl_bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/fl_edge_detect.sv
// Module: fl_edge_detect
// Synchronises an asynchronous strobe and gives a one-cycle pulse on each
// rising edge. Assumes: the strobe stays high and low for several clk cycles.
module fl_edge_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic level_s;
    logic level_d;

    fl_bit_sync #(.STAGES(STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_i),
        .sync_o  (level_s)
    );

    // Keep the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b0;
        end else begin
            level_d <= level_s;
        end
    end

    assign rise_o = level_s & ~level_d;

endmodule

// File: rtl/fl_shift_reg.sv
// Module: fl_shift_reg
// Frame shift register. On each shift pulse the new bit enters bit 0 and
// older bits move up, so the last bit sent ends in bit 0.
// Assumes: shift_i is a single-cycle pulse aligned with the synchronised data.
module fl_shift_reg #(
    parameter int unsigned WIDTH = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] frame_o
);

    logic [WIDTH-1:0] frame_q;

    // Move the frame up one place and insert the new bit at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (shift_i) begin
            frame_q <= {frame_q[WIDTH-2:0], bit_i};
        end
    end

    assign frame_o = frame_q;

endmodule

// File: rtl/fl_select_decode.sv
// Module: fl_select_decode
// Splits the frame register into the select flags and the segment field.
// The first common's flag is the highest bit of the select field, because it
// is shifted in first. The filler bits are deliberately not decoded.
// Assumes: the register layout from frame_loader_pkg.
module fl_select_decode
    import frame_loader_pkg::*;
#(
    parameter int unsigned SEG_BITS  = SEG_BITS_DEF,
    parameter int unsigned FILL_BITS = FILL_BITS_DEF,
    parameter int unsigned NUM_COM   = NUM_COM_DEF,
    localparam int unsigned FRAME_BITS = SEG_BITS + FILL_BITS + NUM_COM,
    localparam int unsigned SEG_LSB    = FILL_BITS + NUM_COM
) (
    input  logic [FRAME_BITS-1:0] frame_i,
    output logic [NUM_COM-1:0]    sel_o,
    output logic [SEG_BITS-1:0]   seg_o
);

    // Reverse the select field so that index k means common k+1.
    for (genvar k = 0; k < NUM_COM; k++) begin : g_sel
        assign sel_o[k] = frame_i[NUM_COM-1-k];
    end

    assign seg_o = frame_i[SEG_LSB +: SEG_BITS];

endmodule

// File: rtl/fl_latch_bank.sv
// Module: fl_latch_bank
// One display latch per common. On a write pulse, every latch whose select
// flag is set takes the segment field. The others keep their contents.
// Assumes: write_i is a single-cycle pulse.
module fl_latch_bank #(
    parameter int unsigned SEG_BITS = 49,
    parameter int unsigned NUM_COM  = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               write_i,
    input  logic [NUM_COM-1:0]                 sel_i,
    input  logic [SEG_BITS-1:0]                seg_i,
    output logic [NUM_COM-1:0][SEG_BITS-1:0]   lat_o
);

    for (genvar k = 0; k < NUM_COM; k++) begin : g_lat
        logic [SEG_BITS-1:0] lat_q;

        // Write this common's latch when it is selected at a load edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q <= '0;
            end else if (write_i && sel_i[k]) begin
                lat_q <= seg_i;
            end
        end

        assign lat_o[k] = lat_q;
    end

endmodule

// File: rtl/seg_frame_loader.sv
// Module: seg_frame_loader (top)
// Receives serial display frames and writes their segment data into the
// selected per-common latches on the rising edge of the load strobe.
// Assumes: the host keeps each data bit stable for several clk cycles around
// the shift edge, and does not shift and load in the same few clk cycles.
module seg_frame_loader
    import frame_loader_pkg::*;
#(
    parameter int unsigned SEG_BITS    = SEG_BITS_DEF,
    parameter int unsigned FILL_BITS   = FILL_BITS_DEF,
    parameter int unsigned NUM_COM     = NUM_COM_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    localparam int unsigned FRAME_BITS = SEG_BITS + FILL_BITS + NUM_COM
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ser_data_i,
    input  logic                             ser_clk_i,
    input  logic                             load_i,
    output logic [NUM_COM-1:0][SEG_BITS-1:0] com_latch_o
);

    logic                  data_s;
    logic                  shift_rise;
    logic                  load_rise;
    logic [FRAME_BITS-1:0] frame_vec;
    logic [NUM_COM-1:0]    sel_vec;
    logic [SEG_BITS-1:0]   seg_vec;

    // The data line takes the same latency as the shift clock, so both stay aligned.
    fl_bit_sync #(.STAGES(SYNC_STAGES)) data_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ser_data_i),
        .sync_o  (data_s)
    );

    fl_edge_detect #(.STAGES(SYNC_STAGES)) sclk_edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ser_clk_i),
        .rise_o  (shift_rise)
    );

    fl_edge_detect #(.STAGES(SYNC_STAGES)) load_edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (load_i),
        .rise_o  (load_rise)
    );

    fl_shift_reg #(.WIDTH(FRAME_BITS)) shreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_rise),
        .bit_i   (data_s),
        .frame_o (frame_vec)
    );

    fl_select_decode #(
        .SEG_BITS  (SEG_BITS),
        .FILL_BITS (FILL_BITS),
        .NUM_COM   (NUM_COM)
    ) dec_i (
        .frame_i (frame_vec),
        .sel_o   (sel_vec),
        .seg_o   (seg_vec)
    );

    fl_latch_bank #(
        .SEG_BITS (SEG_BITS),
        .NUM_COM  (NUM_COM)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .write_i (load_rise),
        .sel_i   (sel_vec),
        .seg_i   (seg_vec),
        .lat_o   (com_latch_o)
    );

endmodule

// File: rtl/seg_frame_loader_chk.sv
// Module: seg_frame_loader_chk
// Property checker bound to seg_frame_loader. It watches the load pulse, the
// decoded select and segment fields, and the latch outputs.
module seg_frame_loader_chk #(
    parameter int unsigned SEG_BITS = 49,
    parameter int unsigned NUM_COM  = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             load_rise,
    input logic [NUM_COM-1:0]               sel,
    input logic [SEG_BITS-1:0]              seg,
    input logic [NUM_COM-1:0][SEG_BITS-1:0] latches
);

    // Right after reset is released, every segment is off.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latches == '0));

    // Without a load edge no latch moves.
    p_hold_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_rise |=> $stable(latches));

    // A load edge lasts a single cycle, so each strobe writes once.
    p_single_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_rise |=> !load_rise);

    for (genvar k = 0; k < NUM_COM; k++) begin : g_prop
        // A selected latch takes the segment field present at the load edge.
        p_sel_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (load_rise && sel[k]) |=> (latches[k] == $past(seg)));

        // An unselected latch keeps its contents through a load.
        p_unsel_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (load_rise && !sel[k]) |=> $stable(latches[k]));
    end

endmodule

bind seg_frame_loader seg_frame_loader_chk #(
    .SEG_BITS (SEG_BITS),
    .NUM_COM  (NUM_COM)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_rise (load_rise),
    .sel       (sel_vec),
    .seg       (seg_vec),
    .latches   (com_latch_o)
);

// File: tb/seg_frame_loader_tb_top.sv
// Scoreboard bench. Driver tasks shift frames, model the register and the
// latches, and queue expected latch images. A monitor compares them.
module seg_frame_loader_tb_top;

    localparam int SEG = 49;
    localparam int NC  = 4;
    localparam int FB  = 56;

    typedef struct {
        logic [NC-1:0][SEG-1:0] lat;
        string                  tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0;
    logic ser_clk = 1'b0;
    logic load = 1'b0;
    logic [NC-1:0][SEG-1:0] lat_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t sb_q[$];
    logic [FB-1:0]          m_sreg = '0;
    logic [NC-1:0][SEG-1:0] m_lat  = '0;
    logic [NC-1:0]          m_sel  = '0;

    always #2 clk = ~clk;

    seg_frame_loader dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_data_i  (ser_data),
        .ser_clk_i   (ser_clk),
        .load_i      (load),
        .com_latch_o (lat_o)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        wait_clks(4);
        ser_clk = 1'b1;
        m_sreg = {m_sreg[FB-2:0], b};
        wait_clks(4);
        ser_clk = 1'b0;
        wait_clks(3);
    endtask

    // Flags: sel[k] is the flag of common k+1; C1 goes out first.
    task automatic send_frame(input logic [SEG-1:0] seg, input int nseg,
                              input logic [2:0] fill, input logic [NC-1:0] sel);
        for (int i = nseg - 1; i >= 0; i--) send_bit(seg[i]);
        for (int i = 2; i >= 0; i--) send_bit(fill[i]);
        for (int i = 0; i < NC; i++) send_bit(sel[i]);
        m_sel = sel;
    endtask

    task automatic push_exp(input string tag);
        exp_t e;
        e.lat = m_lat;
        e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic raise_load();
        load = 1'b1;
        wait_clks(6);
        for (int k = 0; k < NC; k++)
            if (m_sel[k]) m_lat[k] = m_sreg[FB-1 -: SEG];
    endtask

    task automatic drop_load();
        load = 1'b0;
        wait_clks(6);
    endtask

    task automatic load_and_check(input string tag);
        raise_load();
        drop_load();
        push_exp(tag);
    endtask

    // Monitor: compare each queued image against the latch outputs.
    initial begin
        exp_t e;
        forever begin
            wait (sb_q.size() > 0);
            @(negedge clk);
            e = sb_q.pop_front();
            for (int k = 0; k < NC; k++) begin
                checks++;
                if (lat_o[k] !== e.lat[k]) begin
                    fails++;
                    $display("FAIL %s latch%0d actual=%h expected=%h",
                             e.tag, k, lat_o[k], e.lat[k]);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);
        push_exp("R1 reset clear");

        // R2 R9 R3: full frame with a distinct order pattern into common 1 only
        send_frame(49'h1_2345_6789_ABCD, SEG, 3'b000, 4'b0001);
        load_and_check("R2 R9 R3 C1 only");

        // R3: each remaining flag on its own
        send_frame(49'h0_F0F0_1234_5678, SEG, 3'b000, 4'b0010);
        load_and_check("R3 C2 only");
        send_frame(49'h1_AAAA_5555_0001, SEG, 3'b000, 4'b0100);
        load_and_check("R3 C3 only");
        send_frame(49'h0_8000_0000_0003, SEG, 3'b000, 4'b1000);
        load_and_check("R3 C4 only");

        // R4: two flags at once, then all four with zero data
        send_frame(49'h1_0F1E_2D3C_4B5A, SEG, 3'b000, 4'b0101);
        load_and_check("R4 C1+C3");
        send_frame('0, SEG, 3'b000, 4'b1111);
        load_and_check("R4 all clear");

        // R5: refill, then a load with no flags changes nothing
        send_frame(49'h1_FFFF_0000_FFFF, SEG, 3'b000, 4'b1111);
        load_and_check("R4 all fill");
        send_frame(49'h0_1357_9BDF_2468, SEG, 3'b000, 4'b0000);
        load_and_check("R5 no select");

        // R8: nonzero filler bits do not alter the write
        send_frame(49'h0_CAFE_BABE_1234, SEG, 3'b111, 4'b0010);
        load_and_check("R8 filler ones");
        send_frame(49'h1_1111_2222_3333, SEG, 3'b101, 4'b1000);
        load_and_check("R8 filler mixed");

        // R7: a 30-segment frame; the upper positions keep stale register bits
        send_frame({19'd0, 30'h2BAD_F00D}, 30, 3'b000, 4'b1000);
        load_and_check("R7 short frame");

        // R6: hold the strobe high while a new frame arrives
        send_frame(49'h0_7777_8888_9999, SEG, 3'b000, 4'b0010);
        raise_load();
        push_exp("R6 first write");
        send_frame(49'h1_DEAD_BEEF_0042, SEG, 3'b000, 4'b0001);
        push_exp("R6 no rewrite while high");
        drop_load();
        push_exp("R6 no write on fall");
        raise_load();
        drop_load();
        push_exp("R6 second edge writes");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule